// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt sources and turns them into two request lines for a processor: a normal request and a fast request. Software configures it through a simple 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Each source carries an enable bit, a path-select bit that steers it to the normal or the fast request, and a 4-bit priority. Software can also force any source active.

The normal path arbitrates by priority. A source competes only when its priority is strictly above a global 5-bit threshold. The fast path arbitrates purely by source number. For each path, a vector/status word reports the winning source and its priority. That word and the request line are registered together, so both reflect the state one clock after any change. Enables can be written as whole 32-bit halves, or set and cleared one at a time by writing a source number to a set port or a clear port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the following values hold: control word 0, threshold 0x1F, all enables 0, all path bits 0 (normal), all priorities 0, all force bits 0. Both requests are low and both vector words read 0xFFFFFFFF.
- R2: Writing a value n < 64 to word 0x08 sets enable bit n. Writing n < 64 to word 0x0C clears enable bit n. No other enable bit changes, a value of 64 or more changes nothing, and both ports read 0.
- R3: Each 64-bit per-source set is split across two words. Sources 0–31 sit in the low word and sources 32–63 in the high word, at bit (source mod 32). Low/high addresses are: enable 0x14/0x10, path 0x1C/0x18, raw 0x4C/0x48, force 0x54/0x50, normal pending 0x5C/0x58, fast pending 0x64/0x60.
- R4: A source's raw state is its input OR its force bit, and it is read at 0x48/0x4C. Writes to the raw words and to the other status words (0x40–0x48, 0x58–0x64) are ignored.
- R5: Normal pending is raw AND enable AND path=0. Fast pending is raw AND enable AND path=1.
- R6: Priority group g (sources 8g..8g+7) sits at byte address 0x20 + 4*(7-g). Source s uses bits [4*(s mod 8)+3 : 4*(s mod 8)] of its group.
- R7: The threshold word at 0x04 keeps 5 bits. A normal pending source competes only when its zero-extended priority is strictly greater than the threshold, so 0x1F (and any value of 16 or more) blocks all normal requests.
- R8: Among competing normal sources the highest priority wins, and on a tie the higher source number wins. Word 0x40 reads {winner number in [31:16], winner priority in [15:0]}, or 0xFFFFFFFF when there is no winner, and the normal request is high exactly when a winner exists.
- R9: Word 0x44 reports the highest-numbered fast pending source in the same format, regardless of priority. The fast request is high exactly when any fast pending source exists.
- R10: Both requests and both vector words update on the first clock edge after the input, enable or configuration change that causes them. Pending and raw words read back combinationally from the current state.
- R11: Word 0x00 stores and returns all 32 bits without affecting arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address (bits [1:0] ignored) |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 64 | Raw interrupt levels, one bit per source |
| nreq_o | output | 1 | Normal request to the processor |
| freq_o | output | 1 | Fast request to the processor |

## Verification
A register write lands on the clock edge where it is strobed, so configuration and raw/pending readback are correct from the following half cycle. The requests and vector words take one more edge, because they are registered from those new values. A source input change shows in the pending words at once but reaches the requests only at the next edge. The bench holds a behavioural model that, on each rising edge, forms the expected requests and vectors from its pre-edge state before it applies that edge's write, and it compares at the falling edge. For the directed literal checks, the bench waits one extra falling edge after a configuration write before it reads a vector word. It also checks the vector once just before and once just after the edge that follows an input change.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC  = 64;
    localparam int DW    = 32;
    localparam int PW    = 4;
    localparam int AW    = 7;
    localparam int IDXW  = $clog2(NSRC);
    localparam int GRP   = DW / PW;          // sources per priority word
    localparam int NGRP  = NSRC / GRP;
    localparam int WW    = AW - 2;           // word index width

    typedef logic [IDXW-1:0] src_t;
    typedef logic [PW-1:0]   prio_t;

    typedef struct packed {
        logic  valid;
        src_t  idx;
        prio_t prio;
    } win_t;

    // word indices (byte address / 4)
    localparam logic [WW-1:0] WD_CTRL  = 5'd0;
    localparam logic [WW-1:0] WD_THR   = 5'd1;
    localparam logic [WW-1:0] WD_SETN  = 5'd2;
    localparam logic [WW-1:0] WD_CLRN  = 5'd3;
    localparam logic [WW-1:0] WD_ENH   = 5'd4;
    localparam logic [WW-1:0] WD_ENL   = 5'd5;
    localparam logic [WW-1:0] WD_PATHH = 5'd6;
    localparam logic [WW-1:0] WD_PATHL = 5'd7;
    localparam logic [WW-1:0] WD_NVEC  = 5'd16;
    localparam logic [WW-1:0] WD_FVEC  = 5'd17;
    localparam logic [WW-1:0] WD_RAWH  = 5'd18;
    localparam logic [WW-1:0] WD_RAWL  = 5'd19;
    localparam logic [WW-1:0] WD_FRCH  = 5'd20;
    localparam logic [WW-1:0] WD_FRCL  = 5'd21;
    localparam logic [WW-1:0] WD_NPH   = 5'd22;
    localparam logic [WW-1:0] WD_NPL   = 5'd23;
    localparam logic [WW-1:0] WD_FPH   = 5'd24;
    localparam logic [WW-1:0] WD_FPL   = 5'd25;

    localparam logic [4:0] THR_RESET = 5'h1F;

    // priority words occupy indices 8..15, group index runs downward
    function automatic logic is_prio_word(logic [WW-1:0] w);
        return w[WW-1:3] == 2'b01;
    endfunction

    function automatic logic [2:0] prio_group(logic [WW-1:0] w);
        return ~w[2:0];
    endfunction

    function automatic logic [DW-1:0] vec_word(win_t w);
        return w.valid ? {16'(w.idx), 16'(w.prio)} : '1;
    endfunction
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
    import irq_vec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [WW-1:0]             word,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             ctrl_q,
    output logic [4:0]                thr_q,
    output logic [NSRC-1:0]           en_q,
    output logic [NSRC-1:0]           path_q,
    output logic [NSRC-1:0]           frc_q,
    output logic [NSRC-1:0][PW-1:0]   prio_q
);
    logic num_ok;
    assign num_ok = (wdata[DW-1:IDXW] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            thr_q  <= THR_RESET;
            en_q   <= '0;
            path_q <= '0;
            frc_q  <= '0;
        end else if (we) begin
            case (word)
                WD_CTRL:  ctrl_q <= wdata;
                WD_THR:   thr_q  <= wdata[4:0];
                WD_SETN:  if (num_ok) en_q[wdata[IDXW-1:0]] <= 1'b1;
                WD_CLRN:  if (num_ok) en_q[wdata[IDXW-1:0]] <= 1'b0;
                WD_ENH:   en_q[NSRC-1:DW]   <= wdata;
                WD_ENL:   en_q[DW-1:0]      <= wdata;
                WD_PATHH: path_q[NSRC-1:DW] <= wdata;
                WD_PATHL: path_q[DW-1:0]    <= wdata;
                WD_FRCH:  frc_q[NSRC-1:DW]  <= wdata;
                WD_FRCL:  frc_q[DW-1:0]     <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_prio
        localparam logic [WW-1:0] MY_WORD = WW'(8 + (NGRP - 1 - g));
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g*GRP +: GRP] <= '0;
            else if (we && word == MY_WORD)
                prio_q[g*GRP +: GRP] <= wdata;
        end
    end
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
    import irq_vec_pkg::*;
#(
    parameter bit BY_PRIO = 1'b1
)(
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0][PW-1:0] prio,
    output win_t                    win
);
    // ascending scan: a later (higher-numbered) source replaces an equal one
    if (BY_PRIO) begin : g_prio
        always_comb begin
            win = '0;
            for (int i = 0; i < NSRC; i++) begin
                if (pend[i] && (!win.valid || prio[i] >= win.prio)) begin
                    win.valid = 1'b1;
                    win.idx   = src_t'(i);
                    win.prio  = prio[i];
                end
            end
        end
    end else begin : g_num
        always_comb begin
            win = '0;
            for (int i = 0; i < NSRC; i++) begin
                if (pend[i]) begin
                    win.valid = 1'b1;
                    win.idx   = src_t'(i);
                    win.prio  = prio[i];
                end
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            nreq_o,
    output logic            freq_o
);
    logic [WW-1:0]           word;
    logic [1:0]              unused_lsb;
    logic [DW-1:0]           ctrl_q;
    logic [4:0]              thr_q;
    logic [NSRC-1:0]         en_q, path_q, frc_q;
    logic [NSRC-1:0][PW-1:0] prio_q;
    logic [NSRC-1:0]         raw, npend, fpend, elig;
    win_t                    nwin, fwin, nwin_q, fwin_q;

    assign word       = bus_addr[AW-1:2];
    assign unused_lsb = bus_addr[1:0];

    irq_vec_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .word   (word),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .thr_q  (thr_q),
        .en_q   (en_q),
        .path_q (path_q),
        .frc_q  (frc_q),
        .prio_q (prio_q)
    );

    assign raw   = src_in | frc_q;
    assign npend = raw & en_q & ~path_q;
    assign fpend = raw & en_q &  path_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_thr
        assign elig[i] = npend[i] && ({1'b0, prio_q[i]} > thr_q);
    end

    irq_vec_arb #(.BY_PRIO(1'b1)) u_narb (.pend(elig),  .prio(prio_q), .win(nwin));
    irq_vec_arb #(.BY_PRIO(1'b0)) u_farb (.pend(fpend), .prio(prio_q), .win(fwin));

    always_ff @(posedge clk) begin
        if (rst) begin
            nwin_q <= '0;
            fwin_q <= '0;
        end else begin
            nwin_q <= nwin;
            fwin_q <= fwin;
        end
    end

    assign nreq_o = nwin_q.valid;
    assign freq_o = fwin_q.valid;

    always_comb begin
        bus_rdata = '0;
        if (is_prio_word(word)) begin
            bus_rdata = prio_q[prio_group(word)*GRP +: GRP];
        end else begin
            case (word)
                WD_CTRL:  bus_rdata = ctrl_q;
                WD_THR:   bus_rdata = {{(DW-5){1'b0}}, thr_q};
                WD_ENH:   bus_rdata = en_q[NSRC-1:DW];
                WD_ENL:   bus_rdata = en_q[DW-1:0];
                WD_PATHH: bus_rdata = path_q[NSRC-1:DW];
                WD_PATHL: bus_rdata = path_q[DW-1:0];
                WD_NVEC:  bus_rdata = vec_word(nwin_q);
                WD_FVEC:  bus_rdata = vec_word(fwin_q);
                WD_RAWH:  bus_rdata = raw[NSRC-1:DW];
                WD_RAWL:  bus_rdata = raw[DW-1:0];
                WD_FRCH:  bus_rdata = frc_q[NSRC-1:DW];
                WD_FRCL:  bus_rdata = frc_q[DW-1:0];
                WD_NPH:   bus_rdata = npend[NSRC-1:DW];
                WD_NPL:   bus_rdata = npend[DW-1:0];
                WD_FPH:   bus_rdata = fpend[NSRC-1:DW];
                WD_FPL:   bus_rdata = fpend[DW-1:0];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
    import irq_vec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            we,
    input logic [AW-1:0]   addr,
    input logic [DW-1:0]   wdata,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] path_q,
    input logic [4:0]      thr_q,
    input logic [NSRC-1:0] npend,
    input logic [NSRC-1:0] fpend,
    input logic            nreq,
    input logic            freq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!nreq && !freq));

    // R2
    set_single_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr[AW-1:2] == WD_SETN && wdata[DW-1:IDXW] == '0)
        |=> ($countones(en_q ^ $past(en_q)) <= 1 && en_q[$past(wdata[IDXW-1:0])]));

    // R2
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr[AW-1:2] == WD_CLRN && wdata[DW-1:IDXW] == '0)
        |=> ($countones(en_q ^ $past(en_q)) <= 1 && !en_q[$past(wdata[IDXW-1:0])]));

    // R5
    fast_path_chk: assert property (@(posedge clk) disable iff (rst)
        ((fpend & ~path_q) == '0) && ((npend & path_q) == '0));

    // R7
    thr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_q == THR_RESET) |=> !nreq);

    // R10
    freq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (freq == (|$past(fpend))));

    // R8
    nreq_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && nreq) |-> ($past(npend) != '0));
endmodule

bind irq_vec_ctrl irq_vec_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .en_q   (en_q),
    .path_q (path_q),
    .thr_q  (thr_q),
    .npend  (npend),
    .fpend  (fpend),
    .nreq   (nreq_o),
    .freq   (freq_o)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        nreq_o, freq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_vec_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .nreq_o(nreq_o), .freq_o(freq_o)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_ctrl;
    logic [4:0]  m_thr;
    logic [63:0] m_en, m_path, m_frc;
    logic [3:0]  m_prio [64];
    logic [31:0] e_nvec = 32'hFFFF_FFFF, e_fvec = 32'hFFFF_FFFF;
    logic        e_nreq = 1'b0, e_freq = 1'b0;

    function automatic logic [31:0] pick_normal(logic [63:0] rawv);
        for (int p = 15; p >= 0; p--)
            for (int s = 63; s >= 0; s--)
                if (rawv[s] && m_en[s] && !m_path[s] && int'(m_prio[s]) == p && p > int'(m_thr))
                    return {16'(s), 16'(p)};
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] pick_fast(logic [63:0] rawv);
        for (int s = 63; s >= 0; s--)
            if (rawv[s] && m_en[s] && m_path[s])
                return {16'(s), 12'h0, m_prio[s]};
        return 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_thr = 5'h1F; m_en = 0; m_path = 0; m_frc = 0;
            for (int i = 0; i < 64; i++) m_prio[i] = 0;
            e_nvec = 32'hFFFF_FFFF; e_fvec = 32'hFFFF_FFFF;
            e_nreq = 0; e_freq = 0;
        end else begin
            e_nvec = pick_normal(src_in | m_frc);
            e_fvec = pick_fast(src_in | m_frc);
            e_nreq = (e_nvec != 32'hFFFF_FFFF);
            e_freq = (e_fvec != 32'hFFFF_FFFF);
            if (bus_we) begin
                int w;
                w = int'(bus_addr[6:2]);
                case (w)
                    0: m_ctrl = bus_wdata;
                    1: m_thr = bus_wdata[4:0];
                    2: if (bus_wdata < 64) m_en[bus_wdata[5:0]] = 1'b1;
                    3: if (bus_wdata < 64) m_en[bus_wdata[5:0]] = 1'b0;
                    4: m_en[63:32] = bus_wdata;
                    5: m_en[31:0] = bus_wdata;
                    6: m_path[63:32] = bus_wdata;
                    7: m_path[31:0] = bus_wdata;
                    20: m_frc[63:32] = bus_wdata;
                    21: m_frc[31:0] = bus_wdata;
                    default:
                        if (w >= 8 && w <= 15)
                            for (int k = 0; k < 8; k++)
                                m_prio[(15 - w) * 8 + k] = bus_wdata[4*k +: 4];
                endcase
            end
        end
    end

    function automatic logic [31:0] mread(logic [6:0] a);
        logic [63:0] rawv, np, fp;
        int w;
        rawv = src_in | m_frc;
        np = rawv & m_en & ~m_path;
        fp = rawv & m_en & m_path;
        w = int'(a[6:2]);
        case (w)
            0: return m_ctrl;
            1: return {27'h0, m_thr};
            4: return m_en[63:32];
            5: return m_en[31:0];
            6: return m_path[63:32];
            7: return m_path[31:0];
            16: return e_nvec;
            17: return e_fvec;
            18: return rawv[63:32];
            19: return rawv[31:0];
            20: return m_frc[63:32];
            21: return m_frc[31:0];
            22: return np[63:32];
            23: return np[31:0];
            24: return fp[63:32];
            25: return fp[31:0];
            default: begin
                if (w >= 8 && w <= 15) begin
                    logic [31:0] v;
                    for (int k = 0; k < 8; k++) v[4*k +: 4] = m_prio[(15 - w) * 8 + k];
                    return v;
                end
                return 32'h0;
            end
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // requests compared with the model on every cycle (R10, R8, R9)
    always @(negedge clk) begin
        if (!done) begin
            chk("R8 nreq_o per cycle", 32'(nreq_o), 32'(e_nreq));
            chk("R9 freq_o per cycle", 32'(freq_o), 32'(e_freq));
        end
    end

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, logic [31:0] lit, string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(tag, bus_rdata, lit);
        chk({tag, " model"}, bus_rdata, mread(a));
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 nreq after reset", 32'(nreq_o), 32'h0);
        chk("R1 freq after reset", 32'(freq_o), 32'h0);
        rd(7'h00, 32'h0, "R1 R11 ctrl reset");
        rd(7'h04, 32'h1F, "R1 threshold reset");
        rd(7'h14, 32'h0, "R1 enable low reset");
        rd(7'h18, 32'h0, "R1 path high reset");
        rd(7'h3C, 32'h0, "R1 prio group0 reset");
        rd(7'h40, 32'hFFFF_FFFF, "R1 normal vector idle");
        rd(7'h44, 32'hFFFF_FFFF, "R1 fast vector idle");

        // R11 control word storage
        wr(7'h00, 32'hA5C3_0F01);
        rd(7'h00, 32'hA5C3_0F01, "R11 ctrl stores");

        // R2 / R3 set and clear by number
        wr(7'h08, 32'd5);
        wr(7'h08, 32'd40);
        rd(7'h14, 32'h0000_0020, "R2 R3 set 5 low word");
        rd(7'h10, 32'h0000_0100, "R2 R3 set 40 high word");
        rd(7'h08, 32'h0, "R2 set port reads zero");
        wr(7'h0C, 32'd5);
        rd(7'h14, 32'h0, "R2 clear 5");
        rd(7'h10, 32'h0000_0100, "R2 clear leaves 40");
        wr(7'h08, 32'd64);
        wr(7'h0C, 32'd104);
        rd(7'h14, 32'h0, "R2 out-of-range set ignored");
        rd(7'h10, 32'h0000_0100, "R2 out-of-range clear ignored");

        // R7 threshold gating
        src_in[40] = 1'b1;
        settle(); settle();
        chk("R7 thr 0x1F blocks", 32'(nreq_o), 32'h0);
        rd(7'h58, 32'h0000_0100, "R5 normal pending high");
        wr(7'h04, 32'h0);
        settle();
        chk("R7 prio 0 not above thr 0", 32'(nreq_o), 32'h0);

        // R6 / R8 priority placement and vector
        wr(7'h28, 32'h0000_0009);                 // group 5, source 40 nibble 0
        rd(7'h28, 32'h0000_0009, "R6 group5 readback");
        settle();
        chk("R8 nreq raised", 32'(nreq_o), 32'h1);
        rd(7'h40, 32'h0028_0009, "R8 vector src40 prio9");

        // R4 force + R8 tie by higher number
        wr(7'h08, 32'd7);
        wr(7'h54, 32'h0000_0080);
        wr(7'h3C, 32'h9000_0000);                 // group 0, source 7 nibble 7
        rd(7'h4C, 32'h0000_0080, "R4 raw shows force");
        rd(7'h40, 32'h0028_0009, "R8 tie goes to higher number");
        wr(7'h3C, 32'hC000_0000);
        settle();
        rd(7'h40, 32'h0007_000C, "R8 higher priority wins");
        wr(7'h04, 32'd12);
        settle();
        chk("R7 equal to thr blocked", 32'(nreq_o), 32'h0);
        rd(7'h40, 32'hFFFF_FFFF, "R7 vector idle when gated");
        wr(7'h04, 32'd11);
        settle();
        rd(7'h40, 32'h0007_000C, "R7 above thr passes");

        // R5 / R9 fast path
        wr(7'h1C, 32'h0000_0080);
        settle();
        chk("R9 freq raised", 32'(freq_o), 32'h1);
        chk("R5 normal drops", 32'(nreq_o), 32'h0);
        rd(7'h44, 32'h0007_000C, "R9 fast vector src7");
        rd(7'h64, 32'h0000_0080, "R5 fast pending low");
        rd(7'h5C, 32'h0, "R5 normal pending low empty");
        wr(7'h08, 32'd50);
        wr(7'h18, 32'h0004_0000);
        src_in[50] = 1'b1;
        settle(); settle();
        rd(7'h44, 32'h0032_0000, "R9 highest number beats priority");

        // R4 raw words read-only
        wr(7'h4C, 32'hFFFF_FFFF);
        wr(7'h40, 32'h1234_5678);
        rd(7'h4C, 32'h0000_0080, "R4 raw write ignored");
        rd(7'h44, 32'h0032_0000, "R4 vector write ignored");

        // R10 one-cycle update
        @(negedge clk);
        src_in[50] = 1'b0;
        bus_addr = 7'h44;
        #1;
        chk("R10 before edge", bus_rdata, 32'h0032_0000);
        rd(7'h44, 32'h0007_000C, "R10 after one edge");
        wr(7'h0C, 32'd7);
        settle();
        chk("R10 freq drops", 32'(freq_o), 32'h0);
        rd(7'h44, 32'hFFFF_FFFF, "R9 fast idle");

        // mixed traffic against the model (R3 R5 R8 R9 R10)
        for (int it = 0; it < 600; it++) begin
            logic [4:0]  w;
            logic [31:0] d;
            @(negedge clk);
            src_in = {$urandom, $urandom} & {$urandom, $urandom};
            w = 5'($urandom_range(0, 25));
            case (w)
                5'd1: d = $urandom_range(0, 31);
                5'd2, 5'd3: d = $urandom_range(0, 70);
                default: d = $urandom & $urandom;
            endcase
            bus_addr = {w, 2'b00};
            bus_wdata = d;
            bus_we = ($urandom_range(0, 2) != 0);
            #1;
            chk("R3 R5 R8 R9 readback vs model", bus_rdata, mread(bus_addr));
        end
        @(negedge clk);
        bus_we = 1'b0;
        for (int w = 0; w < 26; w++) begin
            @(negedge clk);
            bus_addr = 7'(w << 2);
            #1;
            chk("R3 sweep vs model", bus_rdata, mread(bus_addr));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule